// File: doc/BRIEF.md
# Chip-Level Hit Map Trigger Processor

This block turns a frame of per-chip hit flags from a two-layer silicon pixel barrel into a small vector of trigger decisions. A flag is set when its readout chip saw at least one pixel hit during the frame. Each new frame comes with a valid strobe. Frames can arrive on every clock. The block first removes disabled chips. It then evaluates every output slot against the same masked frame, and each slot runs the algorithm that its own configuration field selects.

The chips are organised as half-staves that each hold a fixed number of chips. Flag index `h*CHIPS_PER_HS + c` belongs to chip `c` of half-stave `h`. Half-staves below `N_INNER_HS` form the inner layer and the remaining half-staves form the outer layer. A per-half-stave mask assigns each outer half-stave to the upper half or the lower half of the barrel. Hit chips are counted by a registered reduction tree. All decisions are delay-matched, so every result leaves the block a fixed number of cycles after its frame is accepted. This keeps each result tied to exactly one frame and well inside an eight-frame budget.

Configuration is quasi-static. It may only change while no frame is in flight.

Top module: `ptrig_core`

## Requirements
- R1: A chip whose bit in `cfg_chip_en_i` is 0 takes part in no algorithm, and its hit flag is treated as absent.
- R2: Algorithm code 0 (global OR) fires when at least one enabled chip is hit.
- R3: Algorithm code 2 fires when the number of hit enabled chips in half-staves 0 to `N_INNER_HS-1` is greater than or equal to the slot's threshold.
- R4: Algorithm code 1 (coincidence) fires only when, in the same frame, an enabled hit chip sits in an outer half-stave whose `cfg_upper_i` bit is 1 and another sits in an outer half-stave whose bit is 0. Inner chips never count toward this algorithm.
- R5: Algorithm code 3 fires when the count of hit enabled outer-layer chips is greater than or equal to the threshold.
- R6: Algorithm code 4 fires when the count of all hit enabled chips is greater than or equal to the threshold. A threshold of 0 fires on every valid frame, and a threshold above the chip count never fires.
- R7: Algorithm codes 5, 6 and 7 hold their output at 0.
- R8: A frame presented with `frame_valid_i` low produces `trig_valid_o` low and all `trig_o` bits at 0.
- R9: The result of a frame accepted at a clock edge appears on `trig_valid_o` and `trig_o` exactly 5 edges later. Back-to-back frames each get their own result.
- R10: Each slot `s` uses its own code `cfg_alg_sel_i[3s+2:3s]` and its own threshold `cfg_thr_i[CNT_W*s +: CNT_W]`, independently of the other slots, on the same frame.
- R11: While `arst_ni` is low, and until the first result after release, `trig_valid_o` and `trig_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_valid_i | input | 1 | Marks the frame on `frame_hits_i` as valid |
| frame_hits_i | input | N_CHIPS | One hit flag per chip |
| cfg_chip_en_i | input | N_CHIPS | Per-chip enable mask |
| cfg_upper_i | input | N_HS | Upper (1) or lower (0) assignment for each half-stave; used for outer half-staves only |
| cfg_alg_sel_i | input | 3*N_SLOTS | Algorithm code for each slot |
| cfg_thr_i | input | CNT_W*N_SLOTS | Multiplicity threshold for each slot |
| trig_valid_o | output | 1 | The result of a valid frame is present |
| trig_o | output | N_SLOTS | Trigger bit for each slot |

## Verification
The bench builds the block with 8 half-staves of 4 chips, 2 inner half-staves, 5 slots and a group size of 4. This gives a 32-bit hit map in which every chip's membership in a layer and a half can be written by hand. With these sizes the outer reduction group is only partly filled, the counts stay small enough that thresholds of 0 and of one above the chip count are easy to drive, and the all-ones frame saturates every multiplicity. The five slots run all five algorithm codes at once, so slot independence and frame-to-result alignment are visible in every back-to-back vector.

// File: rtl/ptrig_pkg.sv
package ptrig_pkg;

  localparam int SEL_W   = 3;
  localparam int LATENCY = 5;

  typedef enum logic [SEL_W-1:0] {
    ALG_ANY      = 3'd0,
    ALG_UPDOWN   = 3'd1,
    ALG_MULT_IN  = 3'd2,
    ALG_MULT_OUT = 3'd3,
    ALG_MULT_ALL = 3'd4
  } alg_e;

endpackage

// File: rtl/ptrig_rst_sync.sv
module ptrig_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/ptrig_hs_count.sv
// Stage 1: register the masked hit map. Stage 2: count hits per half-stave.
module ptrig_hs_count #(
  parameter int N_HS         = 120,
  parameter int CHIPS_PER_HS = 10,
  localparam int N_CHIPS     = N_HS * CHIPS_PER_HS,
  localparam int HS_CNT_W    = $clog2(CHIPS_PER_HS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [N_CHIPS-1:0]         hits_i,
  input  logic [N_CHIPS-1:0]         en_i,
  output logic                       valid_o,
  output logic [N_HS*HS_CNT_W-1:0]   hs_cnt_o
);

  logic [N_CHIPS-1:0]  hit_d, hit_q;
  logic                v1_q, v2_q;
  logic [HS_CNT_W-1:0] cnt_d [N_HS];
  logic [HS_CNT_W-1:0] cnt_q [N_HS];

  // next state, stage 1
  always_comb begin
    hit_d = hits_i & en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= 1'b0;
      hit_q <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        hit_q <= hit_d;
      end
    end
  end

  // next state, stage 2
  always_comb begin
    for (int h = 0; h < N_HS; h++) begin
      cnt_d[h] = '0;
      for (int c = 0; c < CHIPS_PER_HS; c++) begin
        cnt_d[h] = cnt_d[h] + HS_CNT_W'(hit_q[h*CHIPS_PER_HS + c]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q <= 1'b0;
      for (int h = 0; h < N_HS; h++) begin
        cnt_q[h] <= '0;
      end
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        for (int h = 0; h < N_HS; h++) begin
          cnt_q[h] <= cnt_d[h];
        end
      end
    end
  end

  assign valid_o = v2_q;

  for (genvar h = 0; h < N_HS; h++) begin : g_out
    assign hs_cnt_o[h*HS_CNT_W +: HS_CNT_W] = cnt_q[h];

    // R3: a half-stave can never report more hits than it has chips
    assert_hs_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[h] <= HS_CNT_W'(CHIPS_PER_HS));
  end

endmodule

// File: rtl/ptrig_sum_tree.sv
// Stage 3: group partial sums and layer/half occupancy. Stage 4: layer totals.
module ptrig_sum_tree #(
  parameter int N_HS         = 120,
  parameter int N_INNER_HS   = 40,
  parameter int GRP          = 8,
  parameter int HS_CNT_W     = 4,
  parameter int CNT_W        = 11,
  localparam int N_OUTER_HS  = N_HS - N_INNER_HS,
  localparam int N_GI        = (N_INNER_HS + GRP - 1) / GRP,
  localparam int N_GO        = (N_OUTER_HS + GRP - 1) / GRP
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [N_HS*HS_CNT_W-1:0] hs_cnt_i,
  input  logic [N_HS-1:0]          upper_i,
  output logic                     valid_o,
  output logic [CNT_W-1:0]         in_sum_o,
  output logic [CNT_W-1:0]         out_sum_o,
  output logic [CNT_W-1:0]         all_sum_o,
  output logic                     any_o,
  output logic                     updown_o
);

  logic [HS_CNT_W-1:0] hs_a [N_HS];
  logic [CNT_W-1:0]    gin_d [N_GI];
  logic [CNT_W-1:0]    gin_q [N_GI];
  logic [CNT_W-1:0]    gout_d [N_GO];
  logic [CNT_W-1:0]    gout_q [N_GO];
  logic                up_d, lo_d, all_d;
  logic                up_q, lo_q, all_q, v3_q;
  logic [CNT_W-1:0]    in_d, out_d, in_q, out_q, tot_q;
  logic                any_q, ud_q, v4_q;

  for (genvar h = 0; h < N_HS; h++) begin : g_unpack
    assign hs_a[h] = hs_cnt_i[h*HS_CNT_W +: HS_CNT_W];
  end

  // next state, stage 3
  always_comb begin
    up_d  = 1'b0;
    lo_d  = 1'b0;
    all_d = 1'b0;
    for (int h = 0; h < N_HS; h++) begin
      all_d = all_d | (hs_a[h] != '0);
      if (h >= N_INNER_HS) begin
        if (upper_i[h]) up_d = up_d | (hs_a[h] != '0);
        else            lo_d = lo_d | (hs_a[h] != '0);
      end
    end
    for (int g = 0; g < N_GI; g++) begin
      gin_d[g] = '0;
      for (int k = 0; k < GRP; k++) begin
        if (g*GRP + k < N_INNER_HS) gin_d[g] = gin_d[g] + CNT_W'(hs_a[g*GRP + k]);
      end
    end
    for (int g = 0; g < N_GO; g++) begin
      gout_d[g] = '0;
      for (int k = 0; k < GRP; k++) begin
        if (N_INNER_HS + g*GRP + k < N_HS)
          gout_d[g] = gout_d[g] + CNT_W'(hs_a[N_INNER_HS + g*GRP + k]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v3_q  <= 1'b0;
      up_q  <= 1'b0;
      lo_q  <= 1'b0;
      all_q <= 1'b0;
      for (int g = 0; g < N_GI; g++) gin_q[g]  <= '0;
      for (int g = 0; g < N_GO; g++) gout_q[g] <= '0;
    end else begin
      v3_q <= valid_i;
      if (valid_i) begin
        up_q  <= up_d;
        lo_q  <= lo_d;
        all_q <= all_d;
        for (int g = 0; g < N_GI; g++) gin_q[g]  <= gin_d[g];
        for (int g = 0; g < N_GO; g++) gout_q[g] <= gout_d[g];
      end
    end
  end

  // next state, stage 4
  always_comb begin
    in_d  = '0;
    out_d = '0;
    for (int g = 0; g < N_GI; g++) in_d  = in_d  + gin_q[g];
    for (int g = 0; g < N_GO; g++) out_d = out_d + gout_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v4_q  <= 1'b0;
      in_q  <= '0;
      out_q <= '0;
      tot_q <= '0;
      any_q <= 1'b0;
      ud_q  <= 1'b0;
    end else begin
      v4_q <= v3_q;
      if (v3_q) begin
        in_q  <= in_d;
        out_q <= out_d;
        tot_q <= in_d + out_d;
        any_q <= all_q;
        ud_q  <= up_q & lo_q;
      end
    end
  end

  assign valid_o   = v4_q;
  assign in_sum_o  = in_q;
  assign out_sum_o = out_q;
  assign all_sum_o = tot_q;
  assign any_o     = any_q;
  assign updown_o  = ud_q;

  // R2: occupancy path and counting path must agree on an empty frame
  assert_any_vs_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v4_q |-> (any_q == (tot_q != '0)));

  // R4: a coincidence needs hits, and at least two outer ones
  assert_updown_needs_hits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v4_q && ud_q) |-> (any_q && out_q >= CNT_W'(2)));

endmodule

// File: rtl/ptrig_slot_eval.sv
// Stage 5: per-slot algorithm selection and threshold compare.
module ptrig_slot_eval
  import ptrig_pkg::*;
#(
  parameter int N_SLOTS = 10,
  parameter int CNT_W   = 11
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [CNT_W-1:0]         in_sum_i,
  input  logic [CNT_W-1:0]         out_sum_i,
  input  logic [CNT_W-1:0]         all_sum_i,
  input  logic                     any_i,
  input  logic                     updown_i,
  input  logic [N_SLOTS*SEL_W-1:0] sel_i,
  input  logic [N_SLOTS*CNT_W-1:0] thr_i,
  output logic                     valid_o,
  output logic [N_SLOTS-1:0]       trig_o
);

  logic [N_SLOTS-1:0] dec_d, trig_d, trig_q;
  logic               v5_q;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [CNT_W-1:0] thr;
    alg_e             alg;
    assign thr = thr_i[s*CNT_W +: CNT_W];
    assign alg = alg_e'(sel_i[s*SEL_W +: SEL_W]);

    always_comb begin
      case (alg)
        ALG_ANY:      dec_d[s] = any_i;
        ALG_UPDOWN:   dec_d[s] = updown_i;
        ALG_MULT_IN:  dec_d[s] = (in_sum_i  >= thr);
        ALG_MULT_OUT: dec_d[s] = (out_sum_i >= thr);
        ALG_MULT_ALL: dec_d[s] = (all_sum_i >= thr);
        default:      dec_d[s] = 1'b0;
      endcase
    end
  end

  always_comb begin
    trig_d = valid_i ? dec_d : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v5_q   <= 1'b0;
      trig_q <= '0;
    end else begin
      v5_q   <= valid_i;
      trig_q <= trig_d;
    end
  end

  assign valid_o = v5_q;
  assign trig_o  = trig_q;

  // R8: no trigger bit without a valid result
  assert_quiet_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v5_q |-> (trig_q == '0));

endmodule

// File: rtl/ptrig_core.sv
module ptrig_core
  import ptrig_pkg::*;
#(
  parameter int N_HS         = 120,
  parameter int CHIPS_PER_HS = 10,
  parameter int N_INNER_HS   = 40,
  parameter int N_SLOTS      = 10,
  parameter int GRP          = 8,
  localparam int N_CHIPS     = N_HS * CHIPS_PER_HS,
  localparam int CNT_W       = $clog2(N_CHIPS + 1),
  localparam int HS_CNT_W    = $clog2(CHIPS_PER_HS + 1)
) (
  input  logic                     clk_i,
  input  logic                     arst_ni,
  input  logic                     frame_valid_i,
  input  logic [N_CHIPS-1:0]       frame_hits_i,
  input  logic [N_CHIPS-1:0]       cfg_chip_en_i,
  input  logic [N_HS-1:0]          cfg_upper_i,
  input  logic [N_SLOTS*SEL_W-1:0] cfg_alg_sel_i,
  input  logic [N_SLOTS*CNT_W-1:0] cfg_thr_i,
  output logic                     trig_valid_o,
  output logic [N_SLOTS-1:0]       trig_o
);

  logic                     rst_n;
  logic                     v2, v4;
  logic [N_HS*HS_CNT_W-1:0] hs_cnt;
  logic [CNT_W-1:0]         in_sum, out_sum, all_sum;
  logic                     any_hit, updown;

  ptrig_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  ptrig_hs_count #(
    .N_HS         (N_HS),
    .CHIPS_PER_HS (CHIPS_PER_HS)
  ) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .valid_i  (frame_valid_i),
    .hits_i   (frame_hits_i),
    .en_i     (cfg_chip_en_i),
    .valid_o  (v2),
    .hs_cnt_o (hs_cnt)
  );

  ptrig_sum_tree #(
    .N_HS       (N_HS),
    .N_INNER_HS (N_INNER_HS),
    .GRP        (GRP),
    .HS_CNT_W   (HS_CNT_W),
    .CNT_W      (CNT_W)
  ) u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .valid_i   (v2),
    .hs_cnt_i  (hs_cnt),
    .upper_i   (cfg_upper_i),
    .valid_o   (v4),
    .in_sum_o  (in_sum),
    .out_sum_o (out_sum),
    .all_sum_o (all_sum),
    .any_o     (any_hit),
    .updown_o  (updown)
  );

  ptrig_slot_eval #(
    .N_SLOTS (N_SLOTS),
    .CNT_W   (CNT_W)
  ) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .valid_i   (v4),
    .in_sum_i  (in_sum),
    .out_sum_i (out_sum),
    .all_sum_i (all_sum),
    .any_i     (any_hit),
    .updown_i  (updown),
    .sel_i     (cfg_alg_sel_i),
    .thr_i     (cfg_thr_i),
    .valid_o   (trig_valid_o),
    .trig_o    (trig_o)
  );

  // Edge counter since reset release, so the latency check never looks
  // back past reset.
  logic [2:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      since_rst_q <= '0;
    end else if (since_rst_q != 3'(LATENCY)) begin
      since_rst_q <= since_rst_q + 3'd1;
    end
  end

  // R9: result valid follows frame valid by exactly LATENCY edges
  assert_fixed_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (since_rst_q == 3'(LATENCY)) |-> (trig_valid_o == $past(frame_valid_i, LATENCY)));

  // R11: nothing leaves the block before the first result can exist
  assert_reset_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (since_rst_q != 3'(LATENCY)) |-> (!trig_valid_o && trig_o == '0));

endmodule

// File: tb/sim_ptrig_core.sv
module sim_ptrig_core;

  localparam int N_HS = 8, CPH = 4, N_IN = 2, N_SL = 5, GRP = 4;
  localparam int NC = N_HS * CPH;
  localparam int CW = $clog2(NC + 1);
  localparam int LAT = 5;

  logic            clk = 1'b0;
  logic            arst_n;
  logic            fv;
  logic [NC-1:0]   hits, en;
  logic [N_HS-1:0] upper;
  logic [N_SL*3-1:0]  sel;
  logic [N_SL*CW-1:0] thr;
  logic            tv;
  logic [N_SL-1:0] trig;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ptrig_core #(
    .N_HS(N_HS), .CHIPS_PER_HS(CPH), .N_INNER_HS(N_IN), .N_SLOTS(N_SL), .GRP(GRP)
  ) u0 (
    .clk_i(clk), .arst_ni(arst_n), .frame_valid_i(fv), .frame_hits_i(hits),
    .cfg_chip_en_i(en), .cfg_upper_i(upper), .cfg_alg_sel_i(sel), .cfg_thr_i(thr),
    .trig_valid_o(tv), .trig_o(trig)
  );

  // Map: inner chips 0..7, upper outer chips 8..19, lower outer chips 20..31.
  // Slots: 0 OR, 1 coincidence, 2 inner>=3, 3 outer>=4, 4 total>=5.
  typedef struct packed { logic v; logic [31:0] h; logic [4:0] e; } vec_t;
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0000, 5'h00},  // R2 empty frame
    '{1'b1, 32'h0000_0001, 5'h01},  // R2 inner chip only
    '{1'b1, 32'h0000_0100, 5'h01},  // R4 upper only, no coincidence
    '{1'b1, 32'h0010_0100, 5'h03},  // R4 upper and lower
    '{1'b1, 32'h8000_0100, 5'h01},  // R1 disabled lower chip ignored
    '{1'b1, 32'h8000_0000, 5'h00},  // R1 only disabled chip hit
    '{1'b1, 32'h0000_0007, 5'h05},  // R3 inner count 3
    '{1'b1, 32'h0000_010F, 5'h15},  // R3 R6 inner 4, total 5
    '{1'b1, 32'h000F_0000, 5'h09},  // R5 outer upper 4
    '{1'b1, 32'h00F0_0000, 5'h09},  // R5 outer lower 4
    '{1'b1, 32'h0FF0_0003, 5'h19},  // R5 R6 R10 mixed
    '{1'b1, 32'hFFFF_FFFF, 5'h1F},  // R10 all slots fire
    '{1'b0, 32'hFFFF_FFFF, 5'h00},  // R8 invalid frame
    '{1'b1, 32'h0008_0010, 5'h01}   // R4 inner plus upper, no coincidence
  };

  task automatic check(input string req, input logic [N_SL:0] act, input logic [N_SL:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual valid/trig=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_slot(input int s, input logic [2:0] a, input int t);
    sel[s*3 +: 3] = a;
    thr[s*CW +: CW] = CW'(t);
  endtask

  // One isolated frame; checks the cycle before (R9) and the result cycle.
  task automatic one_frame(input string req, input logic [NC-1:0] h, input logic [N_SL-1:0] e);
    @(negedge clk); fv = 1'b1; hits = h;
    @(negedge clk); fv = 1'b0; hits = '0;
    repeat (3) @(negedge clk);
    check("R9 early", {tv, trig}, '0);
    @(negedge clk);
    check(req, {tv, trig}, {1'b1, e});
    @(negedge clk);
  endtask

  initial begin
    arst_n = 1'b0; fv = 1'b0; hits = '0;
    en = 32'h7FFF_FFFF;
    upper = 8'b0001_1100;
    sel = '0; thr = '0;
    set_slot(0, 3'd0, 0);
    set_slot(1, 3'd1, 0);
    set_slot(2, 3'd2, 3);
    set_slot(3, 3'd3, 4);
    set_slot(4, 3'd4, 5);
    repeat (3) @(negedge clk);
    check("R11 in reset", {tv, trig}, '0);
    fv = 1'b1; hits = '1;
    @(negedge clk);
    arst_n = 1'b1;
    fv = 1'b0; hits = '0;
    repeat (3) @(negedge clk);
    check("R11 after release", {tv, trig}, '0);

    // back-to-back table walk (R9)
    for (int j = 0; j < NV + LAT; j++) begin
      @(negedge clk);
      if (j >= LAT)
        check($sformatf("R9 vector %0d", j - LAT), {tv, trig},
              {VECS[j-LAT].v, VECS[j-LAT].e});
      if (j < NV) begin fv = VECS[j].v; hits = VECS[j].h; end
      else        begin fv = 1'b0;      hits = '0;        end
    end

    // R6 threshold 0 fires on an empty valid frame
    set_slot(4, 3'd4, 0);
    one_frame("R6 thr zero", '0, 5'h10);
    // R6 threshold above chip count never fires
    set_slot(4, 3'd4, NC + 1);
    one_frame("R6 thr above count", '1, 5'h0F);
    // R6 exact boundary: total 4 vs threshold 4
    set_slot(4, 3'd4, 4);
    one_frame("R6 thr equal", 32'h0000_0303, 5'h11);
    set_slot(4, 3'd4, 5);
    // R7 reserved codes
    set_slot(0, 3'd5, 0);
    set_slot(1, 3'd6, 0);
    set_slot(2, 3'd7, 0);
    one_frame("R7 reserved", '1, 5'h18);
    set_slot(0, 3'd0, 0);
    set_slot(1, 3'd1, 0);
    set_slot(2, 3'd2, 3);
    // R1 all chips disabled
    en = '0;
    one_frame("R1 all disabled", '1, 5'h00);
    en = '1;
    // R4 swapped half assignment: chip 8 (hs2) and chip 12 (hs3)
    upper = 8'b0000_0100;
    one_frame("R4 remapped halves", 32'h0000_1100, 5'h03);
    // R10 slots swap roles
    set_slot(0, 3'd4, 2);
    set_slot(4, 3'd0, 0);
    one_frame("R10 swapped slots", 32'h0000_1100, 5'h13);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R9 watchdog expired: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule